// File: doc/BRIEF.md
# Shifter Operand Unit with Carry

This block is the second-operand stage of a processor datapath. It is purely combinational. It takes a 32-bit operand, a 2-bit shift kind and a 5-bit encoded amount, and it produces the shifted value and a carry flag. The encoded amount carries two special meanings. A zero amount on either right shift means a full 32-place shift. A zero amount on the rotate kind selects a single-place rotate through the incoming carry.

A mode input switches the unit to the constant path. In this mode a 12-bit field yields a 32-bit constant. Its low byte is zero-extended and rotated right by twice the value of its top nibble. The carry follows the rotate rules in this mode too. The adder that consumes the result lies outside this block, as do register-supplied amounts above 32.

Top module: `shift_operand_unit`

## Requirements
- R1: With mode_i=0, shift_type_i=2'b00 shifts operand_i left by shift_amt_i. When shift_amt_i=0, result_o equals operand_i and carry_o equals carry_i.
- R2: For a left shift by n in 1..31, carry_o is the last bit shifted out, which is operand_i bit 32-n.
- R3: With mode_i=0, shift_type_i=2'b01 and shift_amt_i=n in 1..31, the unit performs a zero-filling right shift by n. carry_o equals operand_i bit n-1.
- R4: With mode_i=0, shift_type_i=2'b01 and shift_amt_i=0, the unit shifts right by 32. result_o is 0 and carry_o equals operand_i bit 31.
- R5: With mode_i=0, shift_type_i=2'b10 selects a sign-filling right shift by n, and carry_o equals operand_i bit n-1. A shift_amt_i of 0 means n=32: every result bit and carry_o equal operand_i bit 31.
- R6: With mode_i=0, shift_type_i=2'b11 and a nonzero shift_amt_i, the unit rotates operand_i right by shift_amt_i. carry_o equals result_o bit 31.
- R7: With mode_i=0, shift_type_i=2'b11 and shift_amt_i=0, result_o is {carry_i, operand_i[31:1]} and carry_o equals operand_i bit 0.
- R8: With mode_i=1, result_o is {24'b0, imm12_i[7:0]} rotated right by 2*imm12_i[11:8]. When that rotation is nonzero, carry_o equals result_o bit 31.
- R9: With mode_i=1 and imm12_i[11:8]=0, carry_o equals carry_i. In this mode operand_i, shift_type_i and shift_amt_i have no effect on either output.
- R10: With mode_i=0, imm12_i has no effect on either output.
- R11: Both outputs are combinational functions of the current inputs, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 1 | 0: shift operand_i; 1: expand imm12_i |
| operand_i | input | 32 | Value to shift |
| shift_type_i | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate |
| shift_amt_i | input | 5 | Encoded shift amount |
| imm12_i | input | 12 | Packed constant: [11:8] half rotation, [7:0] byte |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Shifted operand or expanded constant |
| carry_o | output | 1 | Outgoing carry flag |

## Verification
Immediate assertions check the following on every evaluation:
- A zero effective amount passes both the value and the carry through.
- The single-place carry rotate places carry_i in bit 31 and takes its carry from operand bit 0.
- A nonzero rotate takes its carry from result bit 31.
- The encoded zero for the right shifts decodes to 32.
- An expanded constant keeps the same number of set bits as its source byte.

The exact bit positions of each shifted value, the carry-out bit index of each shift kind, and the fact that the inputs of the unused path are ignored show up only when the bench's scenarios compare against its reference model.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [2:0] {
    OP_LSL = 3'd0,
    OP_LSR = 3'd1,
    OP_ASR = 3'd2,
    OP_ROR = 3'd3,
    OP_RRX = 3'd4
  } shift_op_e;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shift_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int SW   = $clog2(XLEN),
  parameter int AW   = SW + 1
) (
  input  logic [1:0]    kind_i,
  input  logic [SW-1:0] enc_i,
  output shift_op_e     op_o,
  output logic [AW-1:0] amount_o
);
  localparam logic [AW-1:0] FULL = AW'(XLEN);

  always_comb begin
    op_o     = OP_LSL;
    amount_o = AW'(enc_i);
    unique case (kind_i)
      2'b00: op_o = OP_LSL;
      2'b01: begin
        op_o = OP_LSR;
        if (enc_i == '0) amount_o = FULL;
      end
      2'b10: begin
        op_o = OP_ASR;
        if (enc_i == '0) amount_o = FULL;
      end
      default: begin
        if (enc_i == '0) begin
          op_o     = OP_RRX;
          amount_o = AW'(1);
        end else begin
          op_o = OP_ROR;
        end
      end
    endcase
    // R4/R5: encoded zero on a right shift must mean a full-width shift
    p_right_full_r4: assert (!((kind_i == 2'b01 || kind_i == 2'b10) && enc_i == '0)
                             || amount_o == FULL)
      else $error("right-shift zero not decoded to full width");
  end
endmodule

// File: rtl/shift_imm_expand.sv
module shift_imm_expand #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 8,
  parameter int ROT_W = 4,
  parameter int AW    = $clog2(XLEN) + 1
) (
  input  logic [IMM_W+ROT_W-1:0] field_i,
  output logic [XLEN-1:0]        value_o,
  output logic [AW-1:0]          amount_o
);
  assign value_o  = XLEN'(field_i[IMM_W-1:0]);
  assign amount_o = AW'({field_i[IMM_W+ROT_W-1:IMM_W], 1'b0});
endmodule

// File: rtl/shift_core.sv
module shift_core
  import shift_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int SW   = $clog2(XLEN),
  parameter int AW   = SW + 1
) (
  input  logic [XLEN-1:0] value_i,
  input  shift_op_e       op_i,
  input  logic [AW-1:0]   amount_i,
  input  logic            carry_i,
  output logic [XLEN-1:0] result_o,
  output logic            carry_o
);
  logic [2*XLEN-1:0] wide_l;
  logic [SW-1:0]     last_idx;
  logic [SW-1:0]     rot_m;

  always_comb begin
    wide_l   = {{XLEN{1'b0}}, value_i} << amount_i;
    last_idx = SW'(amount_i - AW'(1));
    rot_m    = amount_i[SW-1:0];
    result_o = value_i;
    carry_o  = carry_i;
    if (amount_i != '0) begin
      unique case (op_i)
        OP_LSL: begin
          result_o = wide_l[XLEN-1:0];
          carry_o  = wide_l[XLEN];
        end
        OP_LSR: begin
          result_o = value_i >> amount_i;
          carry_o  = value_i[last_idx];
        end
        OP_ASR: begin
          result_o = XLEN'($signed(value_i) >>> amount_i);
          carry_o  = value_i[last_idx];
        end
        OP_ROR: begin
          result_o = (value_i >> rot_m) | (value_i << (XLEN - int'(rot_m)));
          carry_o  = result_o[XLEN-1];
        end
        default: begin
          result_o = {carry_i, value_i[XLEN-1:1]};
          carry_o  = value_i[0];
        end
      endcase
    end

    p_zero_pass_r1: assert (amount_i != '0 || (result_o == value_i && carry_o == carry_i))
      else $error("zero amount altered value or carry");
    p_rrx_shape_r7: assert (op_i != OP_RRX ||
                            (result_o[XLEN-1] == carry_i && carry_o == value_i[0]))
      else $error("carry rotate wrong");
    p_ror_carry_r6: assert (op_i != OP_ROR || amount_i == '0 || carry_o == result_o[XLEN-1])
      else $error("rotate carry not from msb");
    p_lsr_full_r4: assert (!(op_i == OP_LSR && amount_i == AW'(XLEN)) || result_o == '0)
      else $error("full logical right not zero");
  end
endmodule

// File: rtl/shift_operand_unit.sv
module shift_operand_unit
  import shift_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 8,
  parameter int ROT_W = 4
) (
  input  logic                   mode_i,
  input  logic [XLEN-1:0]        operand_i,
  input  logic [1:0]             shift_type_i,
  input  logic [$clog2(XLEN)-1:0] shift_amt_i,
  input  logic [IMM_W+ROT_W-1:0] imm12_i,
  input  logic                   carry_i,
  output logic [XLEN-1:0]        result_o,
  output logic                   carry_o
);
  localparam int SW = $clog2(XLEN);
  localparam int AW = SW + 1;

  shift_op_e       dec_op;
  logic [AW-1:0]   dec_amt;
  logic [XLEN-1:0] imm_val;
  logic [AW-1:0]   imm_amt;
  logic [XLEN-1:0] core_val;
  shift_op_e       core_op;
  logic [AW-1:0]   core_amt;

  shift_decode #(.XLEN(XLEN), .SW(SW), .AW(AW)) u_dec (
    .kind_i   (shift_type_i),
    .enc_i    (shift_amt_i),
    .op_o     (dec_op),
    .amount_o (dec_amt)
  );

  shift_imm_expand #(.XLEN(XLEN), .IMM_W(IMM_W), .ROT_W(ROT_W), .AW(AW)) u_imm (
    .field_i  (imm12_i),
    .value_o  (imm_val),
    .amount_o (imm_amt)
  );

  always_comb begin
    if (mode_i) begin
      core_val = imm_val;
      core_op  = OP_ROR;
      core_amt = imm_amt;
    end else begin
      core_val = operand_i;
      core_op  = dec_op;
      core_amt = dec_amt;
    end
  end

  shift_core #(.XLEN(XLEN), .SW(SW), .AW(AW)) u_core (
    .value_i  (core_val),
    .op_i     (core_op),
    .amount_i (core_amt),
    .carry_i  (carry_i),
    .result_o (result_o),
    .carry_o  (carry_o)
  );

  always_comb begin
    // R8: rotation preserves the set-bit count of the source byte
    p_imm_popcount_r8: assert (!mode_i ||
                               $countones(result_o) == $countones(imm12_i[IMM_W-1:0]))
      else $error("expanded constant lost bits");
  end
endmodule

// File: tb/sim_shift_operand_unit.sv
module sim_shift_operand_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_i = 1'b0;
  logic [31:0] operand_i = '0;
  logic [1:0]  shift_type_i = '0;
  logic [4:0]  shift_amt_i = '0;
  logic [11:0] imm12_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  shift_operand_unit u0 (
    .mode_i(mode_i), .operand_i(operand_i), .shift_type_i(shift_type_i),
    .shift_amt_i(shift_amt_i), .imm12_i(imm12_i), .carry_i(carry_i),
    .result_o(result_o), .carry_o(carry_o)
  );

  // Behavioural reference: one place per loop step, returns {carry, result}
  function automatic logic [32:0] model(bit m, bit [1:0] ty, bit [4:0] a,
                                        bit [11:0] imm, bit c, bit [31:0] x);
    bit [31:0] v = x;
    bit cy = c;
    int n;
    if (m) begin
      v = {24'd0, imm[7:0]};
      n = 2 * int'(imm[11:8]);
      for (int i = 0; i < n; i++) v = {v[0], v[31:1]};
      if (n != 0) cy = v[31];
    end else begin
      case (ty)
        2'd0: for (int i = 0; i < int'(a); i++) begin cy = v[31]; v = v << 1; end
        2'd1: begin
          n = (a == 0) ? 32 : int'(a);
          for (int i = 0; i < n; i++) begin cy = v[0]; v = v >> 1; end
        end
        2'd2: begin
          n = (a == 0) ? 32 : int'(a);
          for (int i = 0; i < n; i++) begin cy = v[0]; v = {v[31], v[31:1]}; end
        end
        default: begin
          if (a == 0) begin
            cy = v[0];
            v  = {c, v[31:1]};
          end else begin
            for (int i = 0; i < int'(a); i++) v = {v[0], v[31:1]};
            cy = v[31];
          end
        end
      endcase
    end
    return {cy, v};
  endfunction

  function automatic string tag_of(bit m, bit [1:0] ty, bit [4:0] a, bit [11:0] imm);
    if (m) return (imm[11:8] == 0) ? "R9" : "R8";
    case (ty)
      2'd0: return (a == 0) ? "R1" : "R2";
      2'd1: return (a == 0) ? "R4" : "R3";
      2'd2: return "R5";
      default: return (a == 0) ? "R7" : "R6";
    endcase
  endfunction

  // Drive after the falling edge, sample 1 ns later in the same cycle (R11)
  task automatic apply(bit m, bit [1:0] ty, bit [4:0] a, bit [11:0] imm,
                       bit c, bit [31:0] x, string tag);
    logic [32:0] exp_v;
    @(negedge clk);
    mode_i = m; shift_type_i = ty; shift_amt_i = a; imm12_i = imm;
    carry_i = c; operand_i = x;
    #1;
    exp_v = model(m, ty, a, imm, c, x);
    checks++;
    if ({carry_o, result_o} !== exp_v) begin
      fails++;
      $display("FAIL %s: got carry=%0b result=%08h, expected carry=%0b result=%08h",
               tag, carry_o, result_o, exp_v[32], exp_v[31:0]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit m; bit [1:0] ty; bit [4:0] a; bit [11:0] imm; bit c; bit [31:0] x;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    // quiet state: all-zero inputs give zero outputs
    apply(0, 2'd0, 5'd0, 12'h000, 0, 32'h0, "R1");
    // R1 pass-through with both carry values
    apply(0, 2'd0, 5'd0, 12'hFFF, 1, 32'hDEADBEEF, "R1");
    apply(0, 2'd0, 5'd0, 12'h000, 0, 32'hDEADBEEF, "R1");
    // R2 left shift carry
    apply(0, 2'd0, 5'd1, 12'h000, 0, 32'h80000001, "R2");
    apply(0, 2'd0, 5'd31, 12'h000, 0, 32'h00000003, "R2");
    // R3 logical right
    apply(0, 2'd1, 5'd4, 12'h000, 0, 32'hF000000F, "R3");
    apply(0, 2'd1, 5'd31, 12'h000, 1, 32'h40000000, "R3");
    // R4 encoded 32
    apply(0, 2'd1, 5'd0, 12'h000, 0, 32'h80000000, "R4");
    apply(0, 2'd1, 5'd0, 12'h000, 1, 32'h7FFFFFFF, "R4");
    // R5 arithmetic right, both signs and encoded 32
    apply(0, 2'd2, 5'd8, 12'h000, 0, 32'h80000180, "R5");
    apply(0, 2'd2, 5'd0, 12'h000, 0, 32'h80000000, "R5");
    apply(0, 2'd2, 5'd0, 12'h000, 1, 32'h7FFFFFFF, "R5");
    // R6 rotate
    apply(0, 2'd3, 5'd1, 12'h000, 0, 32'h00000001, "R6");
    apply(0, 2'd3, 5'd16, 12'h000, 1, 32'h12345678, "R6");
    // R7 rotate through carry
    apply(0, 2'd3, 5'd0, 12'h000, 1, 32'h00000002, "R7");
    apply(0, 2'd3, 5'd0, 12'h000, 0, 32'hFFFFFFFF, "R7");
    // R8 constants
    apply(1, 2'd0, 5'd0, 12'h1FF, 0, 32'h0, "R8");
    apply(1, 2'd0, 5'd0, 12'hF81, 0, 32'h0, "R8");
    apply(1, 2'd0, 5'd0, 12'h401, 1, 32'h0, "R8");
    // R9 zero rotation keeps carry, shift inputs ignored
    apply(1, 2'd3, 5'd0, 12'h0AB, 1, 32'hFFFFFFFF, "R9");
    apply(1, 2'd1, 5'd7, 12'h0FF, 0, 32'h12345678, "R9");
    // R10 imm12 ignored in shift mode
    apply(0, 2'd2, 5'd3, 12'hABC, 0, 32'h80000004, "R10");
    apply(0, 2'd2, 5'd3, 12'h123, 0, 32'h80000004, "R10");
    // random sweep, tagged by the requirement each case falls under
    for (int k = 0; k < 400; k++) begin
      m = $urandom_range(0, 1); ty = 2'($urandom); a = 5'($urandom);
      if ($urandom_range(0, 3) == 0) a = 5'd0;
      imm = 12'($urandom); c = $urandom_range(0, 1); x = $urandom;
      apply(m, ty, a, imm, c, x, tag_of(m, ty, a, imm));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule